// File: doc/BRIEF.md
# Masked Associative Search Memory

This block is a small content-addressable store. It holds a parameterised number of words of parameterised width. Writes go to an explicit word address through an ordinary decoder. Lookups go by content. A search register holds the value to look for. A column-mask register picks which bit positions take part in the comparison, and the same mask applies to every stored word.

When a search is issued, every stored word is compared with the masked search value at the same time. The per-word results are captured in a match vector on that clock edge, with one flag per word. The vector keeps its value until the next search or reset. A single any-hit output reports whether any flag is set, so a caller can test for a hit without scanning the vector.

Each word carries a valid bit. Reset clears every valid bit, and a write to a word sets its bit. A word that has never been written can never report a hit.

Top module: `assoc_search_mem`

## Requirements
- R1: A mask bit of 1 makes that column take part in the comparison. A mask bit of 0 removes the column from the comparison entirely; it does not mean "look for a 0".
- R2: Bit i of `match_vec` belongs to word i. It is set only when word i is valid and every column enabled by the mask holds the same bit as the search register.
- R3: All words are compared in parallel. The full result is loaded into `match_vec` at the clock edge where `search` is high, and it is visible right after that edge.
- R4: With an all-zero mask, a search sets the flag of every valid word.
- R5: When `wr_en` is high, a clock edge stores `wr_data` at word `wr_addr` and marks that word valid. No other word changes.
- R6: Reset clears every valid bit. An invalid word never raises its flag, even with an all-zero mask.
- R7: When a write and a search fall on the same edge, the search compares against the contents as they were before the write.
- R8: `arg_load` loads the search register and `key_load` loads the mask register. A search uses the values these registers hold before the edge, so a load on the same edge as a search affects only later searches.
- R9: Reset clears `match_vec` to zero. Without a search, `match_vec` holds its value.
- R10: `any_match` is 1 exactly when at least one bit of `match_vec` is 1.
- R11: Take a 4-word, 4-bit instance. Store 1001, 1101 and 1011 at words 0, 1 and 2, and leave word 3 unwritten. A search with value 1010 and mask 1100 gives `match_vec` = 0101 (words 0 and 2 hit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| arg_load | input | 1 | Load `arg_in` into the search register |
| arg_in | input | WIDTH | New search value |
| key_load | input | 1 | Load `key_in` into the mask register |
| key_in | input | WIDTH | New column mask (1 = compare) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Word address for a write |
| wr_data | input | WIDTH | Data to store |
| search | input | 1 | Issue a search on this edge |
| match_vec | output | WORDS | Per-word hit flags from the last search |
| any_match | output | 1 | OR of all hit flags |

## Verification
A corrupt stored word, a stale valid bit or a wrong mask register shows up as a wrong flag in `match_vec`. It appears one edge after the first search whose enabled columns touch the bad state. A search with a full mask or an empty mask exposes such faults right away. Ordering faults show only on edges where two events collide: a write or register load on the same edge as a search. Because the match vector holds its value, a missing hold or an early update shows up as a changed vector on an idle cycle.

// File: rtl/assoc_search_mem.sv
module assoc_search_mem #(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arg_load,
  input  logic [WIDTH-1:0] arg_in,
  input  logic             key_load,
  input  logic [WIDTH-1:0] key_in,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             search,
  output logic [WORDS-1:0] match_vec,
  output logic             any_match
);

  logic [WIDTH-1:0] arg_q, key_q;
  logic [WIDTH-1:0] store_q [WORDS];
  logic [WORDS-1:0] valid_q;
  logic [WORDS-1:0] hit;
  logic [WORDS-1:0] match_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg_q <= '0;
      key_q <= '0;
    end else begin
      if (arg_load) arg_q <= arg_in;
      if (key_load) key_q <= key_in;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic sel;
    assign sel = wr_en && (wr_addr == AW'(w));

    always_ff @(posedge clk) begin
      if (sel) store_q[w] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)   valid_q[w] <= 1'b0;
      else if (sel) valid_q[w] <= 1'b1;
    end

    assign hit[w] = valid_q[w] && (&(~(arg_q ^ store_q[w]) | ~key_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      match_q <= '0;
    else if (search) match_q <= hit;
  end

  assign match_vec = match_q;
  assign any_match = |match_q;

  // R9
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !search |=> $stable(match_vec));

  // R9
  match_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (match_vec == '0));

  // R6
  invalid_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    search |=> ((match_vec & ~$past(valid_q)) == '0));

  // R4
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (search && key_q == '0) |=> (match_vec == $past(valid_q)));

  // R5
  write_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_addr)]);

  // R8
  arg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arg_load |=> (arg_q == $past(arg_in)));

endmodule

// File: tb/assoc_search_mem_tb.sv
module assoc_search_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 4;
  localparam int WIDTH = 4;
  localparam int AW = 2;

  // {search value, mask, expected match_vec}; words hold 1001,1101,1011, word 3 empty
  localparam logic [11:0] TV [6] = '{
    {4'b1010, 4'b1100, 4'b0101},  // R11
    {4'b1010, 4'b0000, 4'b0111},  // R4
    {4'b1101, 4'b1111, 4'b0010},  // R2
    {4'b0000, 4'b0001, 4'b0000},  // R1
    {4'b0000, 4'b0110, 4'b0001},  // R1
    {4'b1111, 4'b1000, 4'b0111}   // R2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arg_load = 1'b0, key_load = 1'b0, wr_en = 1'b0, search = 1'b0;
  logic [WIDTH-1:0] arg_in = '0, key_in = '0, wr_data = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [WORDS-1:0] match_vec;
  logic any_match;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_search_mem #(.WORDS(WORDS), .WIDTH(WIDTH)) u_dut (
    .clk, .rst_n, .arg_load, .arg_in, .key_load, .key_in,
    .wr_en, .wr_addr, .wr_data, .search, .match_vec, .any_match);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [WORDS-1:0] exp);
    checks++;
    if (match_vec !== exp) begin
      failures++;
      $display("FAIL %s match_vec actual=%b expected=%b", req, match_vec, exp);
    end
    checks++;
    if (any_match !== (|exp)) begin
      failures++;
      $display("FAIL R10 (%s) any_match actual=%b expected=%b", req, any_match, |exp);
    end
  endtask

  task automatic write(logic [AW-1:0] a, logic [WIDTH-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic load(logic [WIDTH-1:0] a, logic [WIDTH-1:0] k);
    arg_load = 1'b1; arg_in = a; key_load = 1'b1; key_in = k;
    step();
    arg_load = 1'b0; key_load = 1'b0;
  endtask

  task automatic do_search();
    search = 1'b1;
    step();
    search = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check("R9 reset", 4'b0000);

    load(4'b0000, 4'b0000);
    do_search();
    check("R6 empty store", 4'b0000);

    write(0, 4'b1001);
    write(1, 4'b1101);
    write(2, 4'b1011);

    for (int i = 0; i < 6; i++) begin
      load(TV[i][11:8], TV[i][7:4]);
      do_search();
      check("R3 table", TV[i][3:0]);
    end

    // R7: write word 3 on the same edge as a search
    load(4'b1010, 4'b1111);
    wr_en = 1'b1; wr_addr = 3; wr_data = 4'b1010; search = 1'b1;
    step();
    wr_en = 1'b0; search = 1'b0;
    check("R7 old contents", 4'b0000);
    do_search();
    check("R7 new contents", 4'b1000);

    // R8: a load on the search edge is not used by that search
    arg_load = 1'b1; arg_in = 4'b0000; search = 1'b1;
    step();
    arg_load = 1'b0; search = 1'b0;
    check("R8 old search value", 4'b1000);
    do_search();
    check("R8 new search value", 4'b0000);

    // R9: hold without search
    load(4'b1010, 4'b1111);
    do_search();
    load(4'b0110, 4'b0000);
    step(); step();
    check("R9 hold", 4'b1000);

    // R5: overwrite word 1, others unchanged
    write(1, 4'b1010);
    load(4'b1010, 4'b1111);
    do_search();
    check("R5 overwrite", 4'b1010);
    load(4'b1001, 4'b1111);
    do_search();
    check("R5 neighbour kept", 4'b0001);

    // R6: reset clears valid bits
    do_reset();
    check("R9 reset again", 4'b0000);
    load(4'b0000, 4'b0000);
    do_search();
    check("R6 invalid after reset", 4'b0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule